// File: doc/BRIEF.md
# SRAM Burst Access Sequencer

This block is a bus master for an asynchronous, byte-wide static RAM. It uses three active-low controls: chip select, read strobe and write strobe. A single command gives a start address, a byte count, a direction and, for writes, a choice of two data sources. Writes can take bytes from a stream or fill the range with a constant. The block loads the address counter once and then runs the strobes for each byte. After every byte it steps the address by one, so a burst of any length needs only one address setup.

For a read, the block lowers the read strobe and holds it for a fixed number of clock cycles. It then samples the data bus and raises the strobe again. The sampled byte goes out on a valid/ready stream, and the next byte is not started until the consumer accepts the current one. For a write, the block lowers the write strobe and then drives the byte onto the bus. It raises the strobe while the bus is still driven, which commits the byte. The data bus driver is enabled only while a write byte is being committed. A zero-length command ends at once. The surrounding logic sees a busy level and a one-cycle done pulse.

Top module: `sram_burst_master`

## Requirements
- R1: After reset, mem_cs_n, mem_rd_n and mem_wr_n are high, mem_dq_oe, busy, done, rd_valid and wr_ready are low, and cmd_ready is high.
- R2: mem_rd_n and mem_wr_n are never low in the same cycle, and neither is low while mem_cs_n is high.
- R3: A non-zero command first has one setup cycle. In that cycle mem_cs_n is low, both strobes are high and mem_addr equals cmd_addr.
- R4: For each read byte, mem_rd_n is low for exactly RD_WAIT cycles (default 8). The byte on mem_dq_in in the last of those cycles is presented on rd_data, and mem_rd_n is high while rd_valid is high.
- R5: A read burst delivers the bytes at start, start+1, … in order. rd_valid and rd_data hold steady until rd_ready is seen.
- R6: For each write byte, mem_wr_n falls, mem_dq_oe rises with the byte on mem_dq_out, and mem_wr_n then rises while the bus is still driven and the address is unchanged. Successive bytes go to successive addresses.
- R7: A write with cmd_fill set writes 8'hFF to every address in the range and never raises wr_ready.
- R8: mem_cs_n stays low from the setup cycle to the last byte. In the cycle done is high, mem_cs_n is high and mem_dq_oe is low. done lasts one cycle.
- R9: mem_dq_oe is never high during a read command or while mem_cs_n is high.
- R10: busy is high from the cycle after a command is accepted through the done cycle. cmd_ready is low whenever busy is high.
- R11: A command with cmd_len of 0 gives a done pulse without ever pulling mem_cs_n low.
- R12: The address counter wraps from all ones to zero within a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_addr | input | AW | First byte address |
| cmd_len | input | LW | Number of bytes, 0 allowed |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_fill | input | 1 | With cmd_write: write 8'hFF instead of stream data |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes read byte |
| rd_data | output | 8 | Read byte |
| mem_addr | output | AW | Address to the RAM |
| mem_dq_in | input | 8 | Data bus as seen from the RAM side |
| mem_dq_out | output | 8 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
Stream writes are tried both with gaps and with back-to-back data. Each one is read back with and without consumer stalls. A match shows that the address stepping and the strobe handshake hold under backpressure. Fill writes are read back to tell the constant source apart from the stream source, since no stream data is offered and 8'hFF must still appear. Reads of untouched memory show that sampling happens at the end of the wait window. A burst that crosses the top of the address space, together with zero-length reads and writes, covers the wrap and the immediate-completion paths.

// File: rtl/sbm_pkg.sv
// Shared types for the SRAM burst sequencer.
package sbm_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_RD_LOW,
        S_RD_HOLD,
        S_WR_LOW,
        S_WR_DRIVE,
        S_WR_RISE,
        S_END
    } sbm_state_e;

    localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/sbm_addr_ctr.sv
// Address counter: parallel load at command start, +1 per step.
// Assumes load and step are never requested in the same cycle by the owner;
// load wins if they are. Wraps modulo 2**AW.
module sbm_addr_ctr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;

    // Hold, load or advance the address.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (load)   addr_q <= load_val;
        else if (step)   addr_q <= addr_q + AW'(1);
    end

    assign addr = addr_q;

    // R6 / R12: one step moves the address by exactly one, wrapping at the top.
    p_addr_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr_q == AW'($past(addr_q) + AW'(1))));
endmodule

// File: rtl/sbm_remain.sv
// Remaining byte counter: loaded with the length, decremented per byte.
// Assumes dec is only requested while at least one byte is left.
module sbm_remain #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [LW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [LW-1:0] rem_q;

    // Track how many bytes are still owed.
    always_ff @(posedge clk) begin
        if (!rst_n)     rem_q <= '0;
        else if (load)  rem_q <= load_val;
        else if (dec)   rem_q <= rem_q - LW'(1);
    end

    assign last = (rem_q == LW'(1));

    // R8: the sequencer never asks for more bytes than the command carried.
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (rem_q != '0));
endmodule

// File: rtl/sbm_rd_timer.sv
// Read wait timer: counts cycles while run is high and flags the last one.
// Assumes WAIT >= 2; the count restarts whenever run is low.
module sbm_rd_timer #(
    parameter int WAIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int TW = (WAIT > 1) ? $clog2(WAIT) : 1;

    logic [TW-1:0] cnt_q;

    // Count strobe-low cycles, clearing outside the wait window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + TW'(1);
    end

    assign expire = run && (cnt_q == TW'(WAIT - 1));

    // R4: once the wait has expired the sequencer leaves the strobe window.
    p_expire_leaves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !run);
endmodule

// File: rtl/sram_burst_master.sv
// SRAM burst access sequencer.
// Drives an asynchronous byte-wide RAM with active-low select and strobes.
// One address load per command, then per-byte strobe pulses with a +1 step.
// Assumes the RAM returns data within RD_WAIT cycles of the read strobe
// falling and latches on the rising edge of the write strobe.
module sram_burst_master
    import sbm_pkg::*;
#(
    parameter int AW      = 16,
    parameter int LW      = 16,
    parameter int RD_WAIT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [AW-1:0] cmd_addr,
    input  logic [LW-1:0] cmd_len,
    input  logic          cmd_write,
    input  logic          cmd_fill,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [7:0]    wr_data,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [7:0]    rd_data,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_dq_in,
    output logic [7:0]    mem_dq_out,
    output logic          mem_dq_oe,
    output logic          mem_cs_n,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic          busy,
    output logic          done
);
    localparam int CW = $clog2(RD_WAIT + 2);

    sbm_state_e state_q, state_d;
    logic       is_wr_q, is_fill_q;
    logic [7:0] rd_byte_q, wr_byte_q;
    logic       accept, addr_step, rem_dec, rem_last, tmr_run, tmr_expire;
    logic       take_wr;

    assign accept    = cmd_valid && cmd_ready;
    assign take_wr   = (state_q == S_WR_LOW) && (is_fill_q || wr_valid);
    assign tmr_run   = (state_q == S_RD_LOW);
    assign rem_dec   = ((state_q == S_RD_HOLD) && rd_ready) || (state_q == S_WR_RISE);
    assign addr_step = rem_dec && !rem_last;

    sbm_addr_ctr #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cmd_addr),
        .step     (addr_step),
        .addr     (mem_addr)
    );

    sbm_remain #(.LW(LW)) u_remain (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cmd_len),
        .dec      (rem_dec),
        .last     (rem_last)
    );

    sbm_rd_timer #(.WAIT(RD_WAIT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .expire (tmr_expire)
    );

    // Next-state selection for the strobe sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (accept) state_d = (cmd_len == '0) ? S_END : S_SETUP;
            S_SETUP:    state_d = is_wr_q ? S_WR_LOW : S_RD_LOW;
            S_RD_LOW:   if (tmr_expire) state_d = S_RD_HOLD;
            S_RD_HOLD:  if (rd_ready) state_d = rem_last ? S_END : S_RD_LOW;
            S_WR_LOW:   if (take_wr) state_d = S_WR_DRIVE;
            S_WR_DRIVE: state_d = S_WR_RISE;
            S_WR_RISE:  state_d = rem_last ? S_END : S_WR_LOW;
            S_END:      state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Latch the command direction and data source at accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_wr_q   <= 1'b0;
            is_fill_q <= 1'b0;
        end else if (accept) begin
            is_wr_q   <= cmd_write;
            is_fill_q <= cmd_write && cmd_fill;
        end
    end

    // Capture the read byte on the last cycle of the wait window.
    always_ff @(posedge clk) begin
        if (!rst_n)          rd_byte_q <= '0;
        else if (tmr_expire) rd_byte_q <= mem_dq_in;
    end

    // Capture the byte to write from the stream or the fill constant.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_byte_q <= '0;
        else if (take_wr) wr_byte_q <= is_fill_q ? FILL_BYTE : wr_data;
    end

    // Decode pins and handshakes from the state.
    always_comb begin
        cmd_ready  = (state_q == S_IDLE);
        busy       = (state_q != S_IDLE);
        done       = (state_q == S_END);
        mem_cs_n   = (state_q == S_IDLE) || (state_q == S_END);
        mem_rd_n   = (state_q != S_RD_LOW);
        mem_wr_n   = !((state_q == S_WR_LOW) || (state_q == S_WR_DRIVE));
        mem_dq_oe  = (state_q == S_WR_DRIVE) || (state_q == S_WR_RISE);
        mem_dq_out = wr_byte_q;
        wr_ready   = (state_q == S_WR_LOW) && !is_fill_q;
        rd_valid   = (state_q == S_RD_HOLD);
        rd_data    = rd_byte_q;
    end

    // ---------------- checker logic ----------------
    logic [CW-1:0] chk_rd_low_q;

    // Count consecutive cycles with the read strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n || mem_rd_n) chk_rd_low_q <= '0;
        else                    chk_rd_low_q <= chk_rd_low_q + CW'(1);
    end

    // R2
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_rd_n && !mem_wr_n));
    p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wr_n) |-> !mem_cs_n);
    // R3
    p_setup_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> (mem_rd_n && mem_wr_n));
    // R4
    p_rd_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_n) |-> (chk_rd_low_q == CW'(RD_WAIT)));
    p_rd_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> mem_rd_n);
    // R5
    p_rd_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    // R6
    p_wr_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_wr_n) && !mem_cs_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));
    // R8
    p_end_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_cs_n && !mem_dq_oe));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    p_oe_in_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_cs_n && mem_rd_n));
    // R10
    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready);
    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);
endmodule

// File: tb/sram_burst_master_test.sv
module sram_burst_master_test;
    localparam int AW = 16;
    localparam int LW = 16;
    localparam int RD_WAIT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [AW-1:0] cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic          cmd_write = 1'b0;
    logic          cmd_fill = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [7:0]    wr_data = '0;
    logic          rd_valid;
    logic          rd_ready = 1'b0;
    logic [7:0]    rd_data;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_dq_in;
    logic [7:0]    mem_dq_out;
    logic          mem_dq_oe;
    logic          mem_cs_n, mem_rd_n, mem_wr_n;
    logic          busy, done;

    always #5 clk = ~clk;

    sram_burst_master #(.AW(AW), .LW(LW), .RD_WAIT(RD_WAIT)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .cmd_write(cmd_write), .cmd_fill(cmd_fill),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .busy(busy), .done(done)
    );

    // ---------------- RAM model ----------------
    logic [7:0] mem [logic [AW-1:0]];

    function automatic logic [7:0] peek(logic [AW-1:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign mem_dq_in = (!mem_cs_n && !mem_rd_n) ? peek(mem_addr) : 8'h00;

    // ---------------- scoreboard ----------------
    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [AW-1:0] q_wa [$];
    logic [7:0]    q_wd [$];
    logic [7:0]    q_rd [$];
    logic [AW-1:0] exp_start;
    bit  cur_write, cur_fill;
    int  cs_falls, v_strobe, v_oe, v_busy, v_fill, v_rdhold;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: samples 1 ns after the falling edge, away from driver updates.
    bit prev_cs = 1'b1, prev_wr = 1'b1;
    int rd_low = 0;
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (prev_cs && !mem_cs_n) begin
                cs_falls++;
                chk(mem_rd_n && mem_wr_n, "R3", "strobes high in setup", {mem_rd_n, mem_wr_n}, 3);
                chk(mem_addr == exp_start, "R3", "setup address", mem_addr, exp_start);
            end
            if (!prev_wr && mem_wr_n && !mem_cs_n) begin
                if (q_wa.size() == 0) begin
                    chk(1'b0, "R6", "unexpected write commit", mem_addr, 0);
                end else begin
                    logic [AW-1:0] ea;
                    logic [7:0]    ed;
                    ea = q_wa.pop_front();
                    ed = q_wd.pop_front();
                    chk(mem_addr == ea, "R6", "write address", mem_addr, ea);
                    chk(mem_dq_out == ed, cur_fill ? "R7" : "R6", "write data", mem_dq_out, ed);
                    chk(mem_dq_oe, "R6", "bus driven at commit", mem_dq_oe, 1);
                end
                mem[mem_addr] = mem_dq_out;
            end
            if (!mem_rd_n) rd_low++;
            else if (rd_low != 0) begin
                chk(rd_low == RD_WAIT, "R4", "read strobe width", rd_low, RD_WAIT);
                rd_low = 0;
            end
            if (rd_valid && rd_ready) begin
                if (q_rd.size() == 0) chk(1'b0, "R5", "unexpected read byte", rd_data, 0);
                else begin
                    logic [7:0] er;
                    er = q_rd.pop_front();
                    chk(rd_data == er, "R5", "read data", rd_data, er);
                end
            end
            if ((!mem_rd_n && !mem_wr_n) || ((!mem_rd_n || !mem_wr_n) && mem_cs_n)) v_strobe++;
            if (mem_dq_oe && (!cur_write || mem_cs_n)) v_oe++;
            if (busy && cmd_ready) v_busy++;
            if (cur_fill && wr_ready) v_fill++;
            if (rd_valid && !mem_rd_n) v_rdhold++;
            prev_cs = mem_cs_n;
            prev_wr = mem_wr_n;
        end
    end

    // Driver: pushes expectations, issues the command, feeds the streams.
    task automatic run_cmd(logic [AW-1:0] a, int n, bit wr, bit fill, bit stall, logic [7:0] seed);
        cs_falls = 0; v_strobe = 0; v_oe = 0; v_busy = 0; v_fill = 0; v_rdhold = 0;
        exp_start = a; cur_write = wr; cur_fill = wr && fill;
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] ai;
            ai = a + AW'(i);
            if (wr) begin
                q_wa.push_back(ai);
                q_wd.push_back(fill ? 8'hFF : seed + 8'(i * 7));
            end else begin
                q_rd.push_back(peek(ai));
            end
        end
        cmd_addr = a; cmd_len = LW'(n); cmd_write = wr; cmd_fill = fill; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy, "R10", "busy after accept", busy, 1);
        fork
            begin
                if (wr && !fill) begin
                    for (int i = 0; i < n; i++) begin
                        if (stall) repeat (i % 3) @(negedge clk);
                        wr_valid = 1'b1;
                        wr_data = seed + 8'(i * 7);
                        while (!wr_ready) @(negedge clk);
                        @(negedge clk);
                        wr_valid = 1'b0;
                    end
                end else if (!wr) begin
                    for (int i = 0; i < n; i++) begin
                        if (stall) repeat (i % 3 + 1) @(negedge clk);
                        rd_ready = 1'b1;
                        while (!rd_valid) @(negedge clk);
                        @(negedge clk);
                        rd_ready = 1'b0;
                    end
                end
            end
            begin
                while (!done) @(negedge clk);
            end
        join
        #2;
        chk(mem_cs_n, "R8", "select released at done", mem_cs_n, 1);
        chk(!mem_dq_oe, "R8", "bus released at done", mem_dq_oe, 0);
        chk(cs_falls == (n == 0 ? 0 : 1), (n == 0) ? "R11" : "R8", "select low periods", cs_falls, (n == 0 ? 0 : 1));
        chk(q_wa.size() + q_rd.size() == 0, wr ? "R6" : "R5", "bytes left unmoved", q_wa.size() + q_rd.size(), 0);
        chk(v_strobe == 0, "R2", "strobe overlap or outside select", v_strobe, 0);
        chk(v_oe == 0, "R9", "bus driven outside write", v_oe, 0);
        chk(v_busy == 0, "R10", "cmd_ready while busy", v_busy, 0);
        chk(v_fill == 0, "R7", "wr_ready during fill", v_fill, 0);
        chk(v_rdhold == 0, "R4", "read strobe low with rd_valid", v_rdhold, 0);
        @(negedge clk);
        chk(!done, "R8", "done lasts one cycle", done, 0);
        chk(!busy && cmd_ready, "R10", "idle after done", {busy, cmd_ready}, 1);
        q_wa.delete(); q_wd.delete(); q_rd.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(mem_cs_n && mem_rd_n && mem_wr_n, "R1", "controls idle high", {mem_cs_n, mem_rd_n, mem_wr_n}, 7);
        chk(!mem_dq_oe && !busy && !done, "R1", "oe busy done low", {mem_dq_oe, busy, done}, 0);
        chk(cmd_ready && !rd_valid && !wr_ready, "R1", "handshakes idle", {cmd_ready, rd_valid, wr_ready}, 4);
        @(negedge clk);
        // Single byte write then read (R6, R4)
        run_cmd(16'h0100, 1, 1'b1, 1'b0, 1'b0, 8'h3C);
        run_cmd(16'h0100, 1, 1'b0, 1'b0, 1'b0, 8'h00);
        // Bulk write with gaps, bulk read with consumer stalls (R5, R6)
        run_cmd(16'h0200, 6, 1'b1, 1'b0, 1'b1, 8'h11);
        run_cmd(16'h0200, 6, 1'b0, 1'b0, 1'b1, 8'h00);
        // Back-to-back stream write and read
        run_cmd(16'h0210, 5, 1'b1, 1'b0, 1'b0, 8'hC0);
        run_cmd(16'h0210, 5, 1'b0, 1'b0, 1'b0, 8'h00);
        // Fill mode and read back (R7)
        run_cmd(16'h0300, 5, 1'b1, 1'b1, 1'b0, 8'h00);
        run_cmd(16'h0300, 5, 1'b0, 1'b0, 1'b1, 8'h00);
        // Untouched memory read (R4)
        run_cmd(16'h4000, 4, 1'b0, 1'b0, 1'b0, 8'h00);
        // Zero length read and write (R11)
        run_cmd(16'h0500, 0, 1'b0, 1'b0, 1'b0, 8'h00);
        run_cmd(16'h0500, 0, 1'b1, 1'b0, 1'b0, 8'h00);
        // Wrap across the top of the address space (R12)
        run_cmd(16'hFFFE, 4, 1'b1, 1'b0, 1'b0, 8'h71);
        run_cmd(16'hFFFE, 4, 1'b0, 1'b0, 1'b0, 8'h00);
        chk(peek(16'h0001) == 8'(8'h71 + 8'd21), "R12", "wrapped byte stored at 0x0001", peek(16'h0001), 8'(8'h71 + 8'd21));
        finish_sim();
    end
endmodule